// File: doc/BRIEF.md
# Gate Line Scan Sequencer

This block steps through the row (gate) drive lines of a display panel with up to 320 gates, G1 to G320. Once a frame is started, one gate is active at a time. Each line-period tick moves the active gate by one position. The direction can be upward (G1 first) or downward (G320 first). The number of lines in a frame is programmable in groups of eight and cannot exceed the panel's gate count. When the last line of the frame has been driven, the block pulses a frame-done flag, turns all gates off and waits for the next frame start.

Configuration arrives through a small register write port and is first held as a pending value. That value moves into the active configuration only at a frame start, so a frame already in progress keeps its direction and length to the end. The line count controls only how many gates are scanned. It has no effect on how display memory rows map to gates. The active gate is presented in two forms: as a 1-based gate number and as a one-hot enable vector.

Top module: `gls_gate_scan_seq`

## Requirements
- R1: After reset, gate_num is 0, line_valid and frame_done are low, and gate_en is all zeros. The pending configuration resets to direction 0 (upward) with a count field of 0.
- R2: A write with cfg_wr_en high and cfg_wr_addr equal to CFG_ADDR (default 8'h60) loads the pending configuration: cfg_wr_data[6] is the direction (0 upward, 1 downward) and cfg_wr_data[5:0] is the count field. A write to any other address changes nothing.
- R3: One cycle after frame_start, line_valid is high and gate_num shows the first gate of the frame: 1 when the new direction is upward, NUM_GATES when it is downward.
- R4: In upward mode, each line_tick during a frame raises gate_num by one.
- R5: In downward mode, each line_tick during a frame lowers gate_num by one.
- R6: A frame lasts L = min((field+1)*8, NUM_GATES) lines. Line L is shown after L-1 ticks, and the L-th tick ends the frame.
- R7: One cycle after the tick that ends a frame, frame_done is high for exactly one cycle, and line_valid is low with gate_num 0 at the same time. After that, ticks have no effect until the next frame_start.
- R8: A configuration write made during a frame leaves that frame's direction and length unchanged and takes effect at the next frame_start. A write in the same cycle as frame_start also waits for the frame after that one.
- R9: frame_start restarts the scan even in the middle of a frame. When it arrives in the same cycle as line_tick, it takes precedence and the tick is ignored.
- R10: While line_valid is high, gate_en has exactly one bit set, bit gate_num-1. While line_valid is low, gate_en is zero.
- R11: Between ticks, the active gate does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle pulse marking a line period |
| frame_start | input | 1 | One-cycle pulse that starts or restarts a frame |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration write address |
| cfg_wr_data | input | 7 | [6] direction, [5:0] line count field |
| gate_num | output | 9 | Active gate number (1..NUM_GATES), 0 when idle |
| gate_en | output | 320 | One-hot gate enables, bit g-1 drives gate g |
| line_valid | output | 1 | A gate is currently being driven |
| frame_done | output | 1 | One-cycle pulse after the last line of a frame |

## Verification
The following are checked by assertions on every cycle:
- gate_en is one-hot and consistent with gate_num.
- The gate moves by exactly one step, in the active direction, on each tick and holds still between ticks.
- frame_done lasts a single cycle and coincides with line_valid low.
- The active configuration changes only at a frame start.

Only the bench's scenarios can show that a frame has the correct length for each field value, including the clamp at 320 lines. The same is true of four other behaviours: that writes to other addresses are discarded, that a write made mid-frame appears only in the following frame, that a restart combined with a tick lands on the new frame's first gate, and that ticks while idle are ignored.

// File: rtl/gls_pkg.sv
package gls_pkg;

  localparam int FIELD_W = 6;

  typedef struct packed {
    logic                rev;
    logic [FIELD_W-1:0]  field;
  } scan_cfg_t;

  // Lines in one frame: eight-line groups, limited to the panel size.
  function automatic int line_total(input int field, input int gran, input int ngates);
    int n;
    n = (field + 1) * gran;
    return (n > ngates) ? ngates : n;
  endfunction

  // First gate of a frame (1-based numbering).
  function automatic int first_gate(input logic rev, input int ngates);
    return rev ? ngates : 1;
  endfunction

  // Next gate in the scan direction.
  function automatic int next_gate(input int cur, input logic rev);
    return rev ? cur - 1 : cur + 1;
  endfunction

endpackage

// File: rtl/gls_cfg_regs.sv
module gls_cfg_regs
  import gls_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  CFG_ADDR = 8'h60,
  localparam int         DATA_W   = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_start,
  output scan_cfg_t         pend_cfg,
  output scan_cfg_t         act_cfg
);

  logic wr_hit;
  assign wr_hit = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cfg <= '0;
    end else if (wr_hit) begin
      pend_cfg.rev   <= wr_data[FIELD_W];
      pend_cfg.field <= wr_data[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg <= '0;
    end else if (frame_start) begin
      act_cfg <= pend_cfg;
    end
  end

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));

  // R8
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> act_cfg == $past(pend_cfg));

  // R2
  miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(pend_cfg));

endmodule

// File: rtl/gls_scan_ctrl.sv
module gls_scan_ctrl
  import gls_pkg::*;
#(
  parameter int  NUM_GATES = 320,
  parameter int  GRAN      = 8,
  localparam int IDX_W     = $clog2(NUM_GATES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_tick,
  input  scan_cfg_t        start_cfg,
  input  scan_cfg_t        run_cfg,
  output logic [IDX_W-1:0] gate_num,
  output logic             line_valid,
  output logic             frame_done,
  output logic             evt_advance,
  output logic             evt_last
);

  logic [IDX_W-1:0] lines_tot;
  logic [IDX_W-1:0] line_cnt;
  logic [IDX_W-1:0] gate_first;
  logic [IDX_W-1:0] gate_next;
  logic             tick_live;

  assign lines_tot  = IDX_W'(line_total(int'(run_cfg.field), GRAN, NUM_GATES));
  assign gate_first = IDX_W'(first_gate(start_cfg.rev, NUM_GATES));
  assign gate_next  = IDX_W'(next_gate(int'(gate_num), run_cfg.rev));

  assign tick_live   = line_valid && line_tick && !frame_start;
  assign evt_last    = tick_live && (line_cnt == lines_tot - IDX_W'(1));
  assign evt_advance = tick_live && !evt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_valid <= 1'b0;
      frame_done <= 1'b0;
      line_cnt   <= '0;
      gate_num   <= '0;
    end else if (frame_start) begin
      line_valid <= 1'b1;
      frame_done <= 1'b0;
      line_cnt   <= '0;
      gate_num   <= gate_first;
    end else if (evt_last) begin
      line_valid <= 1'b0;
      frame_done <= 1'b1;
      line_cnt   <= '0;
      gate_num   <= '0;
    end else if (evt_advance) begin
      frame_done <= 1'b0;
      line_cnt   <= line_cnt + IDX_W'(1);
      gate_num   <= gate_next;
    end else begin
      frame_done <= 1'b0;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!line_valid && gate_num == '0));

  // R3
  first_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_valid &&
                     gate_num == (run_cfg.rev ? IDX_W'(NUM_GATES) : IDX_W'(1))));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_advance && !run_cfg.rev) |=> gate_num == $past(gate_num) + IDX_W'(1));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_advance && run_cfg.rev) |=> gate_num == $past(gate_num) - IDX_W'(1));

  // R11
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_tick && !frame_start) |=> $stable(gate_num));

  // R6
  gate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (gate_num >= IDX_W'(1) && gate_num <= IDX_W'(NUM_GATES)
                    && line_cnt < lines_tot));

  // R7
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_valid && !frame_start) |=> (!line_valid && gate_num == '0));

endmodule

// File: rtl/gls_gate_decode.sv
module gls_gate_decode #(
  parameter int  NUM_GATES = 320,
  localparam int IDX_W     = $clog2(NUM_GATES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_valid,
  input  logic [IDX_W-1:0]     gate_num,
  output logic [NUM_GATES-1:0] gate_en
);

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_dec
    assign gate_en[g] = line_valid && (gate_num == IDX_W'(g + 1));
  end

  // R10
  en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en));

  // R10
  en_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $countones(gate_en) == 1);

  // R10
  en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> gate_en == '0);

endmodule

// File: rtl/gls_gate_scan_seq.sv
module gls_gate_scan_seq
  import gls_pkg::*;
#(
  parameter int          NUM_GATES = 320,
  parameter int          GRAN      = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  CFG_ADDR  = 8'h60,
  localparam int         IDX_W     = $clog2(NUM_GATES + 1),
  localparam int         DATA_W    = FIELD_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_tick,
  input  logic                 frame_start,
  input  logic                 cfg_wr_en,
  input  logic [ADDR_W-1:0]    cfg_wr_addr,
  input  logic [DATA_W-1:0]    cfg_wr_data,
  output logic [IDX_W-1:0]     gate_num,
  output logic [NUM_GATES-1:0] gate_en,
  output logic                 line_valid,
  output logic                 frame_done
);

  scan_cfg_t pend_cfg;
  scan_cfg_t act_cfg;
  logic      evt_advance;
  logic      evt_last;

  gls_cfg_regs #(
    .ADDR_W   (ADDR_W),
    .CFG_ADDR (CFG_ADDR)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr_en),
    .wr_addr     (cfg_wr_addr),
    .wr_data     (cfg_wr_data),
    .frame_start (frame_start),
    .pend_cfg    (pend_cfg),
    .act_cfg     (act_cfg)
  );

  gls_scan_ctrl #(
    .NUM_GATES (NUM_GATES),
    .GRAN      (GRAN)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_tick   (line_tick),
    .start_cfg   (pend_cfg),
    .run_cfg     (act_cfg),
    .gate_num    (gate_num),
    .line_valid  (line_valid),
    .frame_done  (frame_done),
    .evt_advance (evt_advance),
    .evt_last    (evt_last)
  );

  gls_gate_decode #(
    .NUM_GATES (NUM_GATES)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_valid (line_valid),
    .gate_num   (gate_num),
    .gate_en    (gate_en)
  );

  // R9
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!evt_advance && !evt_last));

endmodule

// File: tb/gls_gate_scan_seq_tb.sv
module gls_gate_scan_seq_tb_top;

  localparam int NG = 320;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_tick = 1'b0;
  logic          frame_start = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [7:0]    cfg_wr_addr = '0;
  logic [6:0]    cfg_wr_data = '0;
  logic [8:0]    gate_num;
  logic [NG-1:0] gate_en;
  logic          line_valid;
  logic          frame_done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gls_gate_scan_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_tick   (line_tick),
    .frame_start (frame_start),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_addr (cfg_wr_addr),
    .cfg_wr_data (cfg_wr_data),
    .gate_num    (gate_num),
    .gate_en     (gate_en),
    .line_valid  (line_valid),
    .frame_done  (frame_done)
  );

  function automatic int exp_lines(input int field);
    int n = 8 * field + 8;
    if (n > NG) n = NG;
    return n;
  endfunction

  function automatic int exp_gate(input bit down, input int k);
    return down ? (NG - k) : (k + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Checks gate number, valid flag and the enable vector together.
  task automatic chk_state(input string req, input bit valid, input int g);
    logic [NG-1:0] e;
    e = '0;
    if (valid) e[g-1] = 1'b1;
    chk({req, " valid"}, int'(line_valid), int'(valid));
    chk({req, " gate"}, int'(gate_num), valid ? g : 0);
    n_chk++;
    if (gate_en !== e) begin
      n_bad++;
      $display("FAIL R10 (%s): gate_en ones=%0d expected one-hot for gate %0d",
               req, $countones(gate_en), valid ? g : 0);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input bit down, input int field);
    cfg_wr_en   = 1'b1;
    cfg_wr_addr = a;
    cfg_wr_data = {down, 6'(field)};
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  // Runs one full frame expecting direction/field; optionally writes mid-frame.
  task automatic play_frame(input bit down, input int field, input int maxgap,
                            input bit inj, input bit inj_down, input int inj_field);
    int tot = exp_lines(field);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk_state("R3", 1'b1, exp_gate(down, 0));
    for (int k = 0; k < tot; k++) begin
      int gap = int'($urandom_range(maxgap, 0));
      repeat (gap) begin
        @(negedge clk);
        chk("R11 hold", int'(gate_num), exp_gate(down, k));
      end
      if (inj && k == 2) begin
        cfg_write(8'h60, inj_down, inj_field);
        chk("R8 mid write", int'(gate_num), exp_gate(down, k));
      end
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      if (k < tot - 1) begin
        chk_state(down ? "R5" : "R4", 1'b1, exp_gate(down, k + 1));
      end else begin
        chk("R6 frame end", int'(frame_done), 1);
        chk_state("R7", 1'b0, 0);
        @(negedge clk);
        chk("R7 done pulse width", int'(frame_done), 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_state("R1", 1'b0, 0);
    chk("R1 done", int'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 tick while idle does nothing
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    @(negedge clk);
    chk_state("R7 idle tick", 1'b0, 0);
    chk("R7 idle done", int'(frame_done), 0);

    // R2: wrong address ignored, defaults (up, 8 lines) remain (R1)
    cfg_write(8'h61, 1'b1, 5);
    play_frame(1'b0, 0, 1, 1'b0, 1'b0, 0);

    // R2: matching write, directed corners R4/R5/R6
    cfg_write(8'h60, 1'b1, 0);
    play_frame(1'b1, 0, 2, 1'b0, 1'b0, 0);
    cfg_write(8'h60, 1'b0, 39);
    play_frame(1'b0, 39, 0, 1'b0, 1'b0, 0);
    cfg_write(8'h60, 1'b1, 63);
    play_frame(1'b1, 63, 1, 1'b0, 1'b0, 0);
    cfg_write(8'h60, 1'b0, 63);
    play_frame(1'b0, 63, 0, 1'b0, 1'b0, 0);

    // R8: mid-frame write affects only the next frame
    cfg_write(8'h60, 1'b0, 1);
    play_frame(1'b0, 1, 1, 1'b1, 1'b1, 2);
    play_frame(1'b1, 2, 1, 1'b0, 1'b0, 0);

    // R9: restart mid-frame with a tick in the same cycle
    cfg_write(8'h60, 1'b0, 3);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
    end
    chk_state("R9 before restart", 1'b1, 4);
    cfg_write(8'h60, 1'b1, 0);
    frame_start = 1'b1;
    line_tick   = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    line_tick   = 1'b0;
    chk_state("R9 restart", 1'b1, NG);
    for (int k = 0; k < 8; k++) begin
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      if (k < 7) chk_state("R9 R5 after restart", 1'b1, NG - k - 1);
      else chk("R9 R6 restarted frame end", int'(frame_done), 1);
    end
    @(negedge clk);

    // Random frames
    for (int f = 0; f < 8; f++) begin
      bit rd = 1'($urandom_range(1, 0));
      int rf = int'($urandom_range(63, 0));
      cfg_write(8'h60, rd, rf);
      repeat (int'($urandom_range(3, 0))) @(negedge clk);
      play_frame(rd, rf, 2, 1'b0, 1'b0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule